// File: doc/BRIEF.md
# Pipelined Binary-Search Associative Lookup

This block looks up a search key and returns the data word stored with it. It uses only plain RAM arrays and no per-word comparators. The keys are held in ascending order in a sorted store of 2^LEVELS−1 entries, at positions 1 to 2^LEVELS−1. A chain of LEVELS compare stages walks a binary search through that store, and each stage reads its own private copy of the key array. Each stage settles one bit of the sorted position. The probe address of stage k is made of the bits already decided, then a 1 at bit LEVELS−1−k, then zeros below it. If the query is greater than the probed key, that bit stays 1. If it is smaller, the bit is cleared. If the two are equal, the position is frozen and a found flag travels with the query. Two further read stages follow the chain. A remap RAM turns the sorted position into the original table address, and a data RAM returns the unordered word held at that address.

One query is accepted per clock, with no handshake. Every slot carries its own key, partial position and found flag, so queries in flight never interfere with one another. The contents are filled through a load port. A target field on that port selects one of three writes: the key, written into all LEVELS copies at once; the remap entry; or the data word. A small mode machine has two states, ST_SEARCH and ST_LOAD. Transition GO_LOAD is taken on any cycle with the load enable high. Transition GO_SEARCH is taken on the first cycle with it low. Queries are accepted only in ST_SEARCH and only while no load is presented, so the first cycle after a load burst is a settle cycle that drops any query.

Top module: `bsam_top`

## Requirements
- R1: After reset, and until the first accepted query has passed through, `r_valid` is 0.
- R2: A query whose key is in the sorted store produces `r_valid`=1 and `r_hit`=1 exactly LEVELS+2 clock edges after it is sampled. `r_data` is then the data word at the table address held in the remap entry for that key's sorted position.
- R3: A query whose key is absent produces `r_valid`=1 and `r_hit`=0 at the same LEVELS+2 latency.
- R4: Queries may be presented on every cycle. Results come out one per cycle, in query order, each matching its own query.
- R5: A load with `ld_tgt`=0 writes `ld_data` as the key at sorted position `ld_addr` in every stage copy. `ld_tgt`=1 writes the remap entry for sorted position `ld_addr`. `ld_tgt`=2 writes the data word at table address `ld_addr`.
- R6: A query presented in a cycle with `ld_en`=1 is dropped: no result appears for it. A load with `ld_tgt`=3 changes no stored contents.
- R7: The smallest key (position 1) and the largest key (position 2^LEVELS−1) are both found. Keys below the smallest or above the largest report a miss.
- R8: The mode machine enters ST_LOAD (GO_LOAD) on any cycle with `ld_en`=1 and returns to ST_SEARCH (GO_SEARCH) on the first cycle with `ld_en`=0. A query presented on that first cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load write strobe |
| ld_tgt | input | 2 | Load target: 0 key, 1 remap, 2 data, 3 none |
| ld_addr | input | LEVELS | Sorted position or table address for the load |
| ld_data | input | max(KEY_W,DATA_W) | Load value (low bits used per target) |
| q_valid | input | 1 | Query present this cycle |
| q_key | input | KEY_W | Query key |
| r_valid | output | 1 | Result present |
| r_hit | output | 1 | Key was found |
| r_data | output | DATA_W | Data word of the found key (undefined on a miss) |

## Verification
Loading and querying are the two functions that can fall in the same cycle. The bench provokes this by presenting a query together with a target-3 load. It also presents a query on the settle cycle right after a load burst. The bench's own mode model predicts that both queries are dropped, and every cycle it flags any result that appears where no accepted query should land. A later query of the key whose data word sat under the ignored load must still return the original word.

// File: rtl/bsam_pkg.sv
package bsam_pkg;
    typedef enum logic [1:0] {
        TGT_KEY  = 2'd0,
        TGT_MAP  = 2'd1,
        TGT_DATA = 2'd2,
        TGT_NONE = 2'd3
    } ld_tgt_e;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOAD   = 1'b1
    } mode_e;
endpackage

// File: rtl/bsam_stage.sv
module bsam_stage #(
    parameter int KEY_W  = 16,
    parameter int LEVELS = 4,
    parameter int STAGE  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LEVELS-1:0] wr_addr,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic              in_valid,
    input  logic [KEY_W-1:0]  in_key,
    input  logic [LEVELS-1:0] in_idx,
    input  logic              in_found,
    output logic              out_valid,
    output logic [KEY_W-1:0]  out_key,
    output logic [LEVELS-1:0] out_idx,
    output logic              out_found
);
    localparam int DEPTH = 1 << LEVELS;
    localparam int BIT   = LEVELS - 1 - STAGE;
    localparam logic [LEVELS-1:0] PROBE_BIT = LEVELS'(1) << BIT;
    localparam logic [LEVELS-1:0] LOW_MASK  = PROBE_BIT - LEVELS'(1);

    logic [KEY_W-1:0]  key_mem [DEPTH];
    logic [LEVELS-1:0] probe_idx;
    logic [KEY_W-1:0]  probe_key;
    logic [LEVELS-1:0] nxt_idx;
    logic              nxt_found;

    always_ff @(posedge clk) begin
        if (wr_en) key_mem[wr_addr] <= wr_key;
    end

    assign probe_idx = in_idx | PROBE_BIT;
    assign probe_key = key_mem[probe_idx];

    always_comb begin
        nxt_idx   = in_idx;
        nxt_found = in_found;
        if (!in_found) begin
            if (in_key == probe_key) begin
                nxt_idx   = probe_idx;
                nxt_found = 1'b1;
            end else if (in_key > probe_key) begin
                nxt_idx = probe_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_key   <= '0;
            out_idx   <= '0;
            out_found <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_key   <= in_key;
            out_idx   <= nxt_idx;
            out_found <= nxt_found;
        end
    end

    // R2
    found_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_found) |=> (out_found && out_idx == $past(in_idx)));

    // R2
    idx_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_idx & LOW_MASK) == '0));
endmodule

// File: rtl/bsam_rdstage.sv
module bsam_rdstage #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          in_valid,
    input  logic          in_hit,
    input  logic [AW-1:0] in_addr,
    output logic          out_valid,
    output logic          out_hit,
    output logic [DW-1:0] out_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_hit   <= in_hit;
            out_data  <= mem[in_addr];
        end
    end

    // R3
    miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_hit) |=> (out_valid && !out_hit));
endmodule

// File: rtl/bsam_top.sv
module bsam_top #(
    parameter int KEY_W  = 16,
    parameter int DATA_W = 16,
    parameter int LEVELS = 4
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            ld_en,
    input  logic [1:0]                                      ld_tgt,
    input  logic [LEVELS-1:0]                               ld_addr,
    input  logic [((KEY_W > DATA_W) ? KEY_W : DATA_W)-1:0]  ld_data,
    input  logic                                            q_valid,
    input  logic [KEY_W-1:0]                                q_key,
    output logic                                            r_valid,
    output logic                                            r_hit,
    output logic [DATA_W-1:0]                               r_data
);
    import bsam_pkg::*;

    mode_e   st_q, st_d;
    ld_tgt_e tgt;
    logic    q_accept, key_we, map_we, data_we;

    logic              v_c     [LEVELS+1];
    logic [KEY_W-1:0]  key_c   [LEVELS+1];
    logic [LEVELS-1:0] idx_c   [LEVELS+1];
    logic              found_c [LEVELS+1];

    logic              map_v, map_h;
    logic [LEVELS-1:0] map_addr;

    assign tgt = ld_tgt_e'(ld_tgt);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_SEARCH;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d     = st_q;
        q_accept = 1'b0;
        key_we   = ld_en && (tgt == TGT_KEY);
        map_we   = ld_en && (tgt == TGT_MAP);
        data_we  = ld_en && (tgt == TGT_DATA);
        unique case (st_q)
            ST_SEARCH: begin
                q_accept = q_valid && !ld_en;
                if (ld_en) st_d = ST_LOAD;       // GO_LOAD
            end
            ST_LOAD: begin
                if (!ld_en) st_d = ST_SEARCH;    // GO_SEARCH
            end
            default: st_d = ST_SEARCH;
        endcase
    end

    assign v_c[0]     = q_accept;
    assign key_c[0]   = q_key;
    assign idx_c[0]   = '0;
    assign found_c[0] = 1'b0;

    for (genvar k = 0; k < LEVELS; k++) begin : g_stage
        bsam_stage #(.KEY_W(KEY_W), .LEVELS(LEVELS), .STAGE(k)) stage_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (key_we),
            .wr_addr  (ld_addr),
            .wr_key   (ld_data[KEY_W-1:0]),
            .in_valid (v_c[k]),
            .in_key   (key_c[k]),
            .in_idx   (idx_c[k]),
            .in_found (found_c[k]),
            .out_valid(v_c[k+1]),
            .out_key  (key_c[k+1]),
            .out_idx  (idx_c[k+1]),
            .out_found(found_c[k+1])
        );
    end

    bsam_rdstage #(.AW(LEVELS), .DW(LEVELS)) remap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (map_we),
        .wr_addr  (ld_addr),
        .wr_data  (ld_data[LEVELS-1:0]),
        .in_valid (v_c[LEVELS]),
        .in_hit   (found_c[LEVELS]),
        .in_addr  (idx_c[LEVELS]),
        .out_valid(map_v),
        .out_hit  (map_h),
        .out_data (map_addr)
    );

    bsam_rdstage #(.AW(LEVELS), .DW(DATA_W)) data_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_we),
        .wr_addr  (ld_addr),
        .wr_data  (ld_data[DATA_W-1:0]),
        .in_valid (map_v),
        .in_hit   (map_h),
        .in_addr  (map_addr),
        .out_valid(r_valid),
        .out_hit  (r_hit),
        .out_data (r_data)
    );

    // R6
    load_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> !v_c[1]);

    // R8
    settle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ld_en) |=> !v_c[1]);

    // R8
    mode_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (st_q == ST_LOAD));
endmodule

// File: tb/bsam_top_tb.sv
module bsam_top_tb_top;
    localparam int KEY_W  = 16;
    localparam int DATA_W = 16;
    localparam int LEVELS = 4;
    localparam int LAT    = LEVELS + 2;
    localparam int N      = (1 << LEVELS) - 1;
    localparam int LD_W   = (KEY_W > DATA_W) ? KEY_W : DATA_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_en = 1'b0;
    logic [1:0] ld_tgt = 2'd0;
    logic [LEVELS-1:0] ld_addr = '0;
    logic [LD_W-1:0] ld_data = '0;
    logic q_valid = 1'b0;
    logic [KEY_W-1:0] q_key = '0;
    logic r_valid, r_hit;
    logic [DATA_W-1:0] r_data;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit prev_ld = 1'b0;
    bit done = 1'b0;

    int skeys [N+1];
    int mapv  [N+1];
    int dmem  [N+1];

    bit    exp_v   [64];
    bit    exp_h   [64];
    int    exp_d   [64];
    string exp_tag [64];
    string cur_tag = "R2";

    always #2.5 clk = ~clk;

    bsam_top #(.KEY_W(KEY_W), .DATA_W(DATA_W), .LEVELS(LEVELS)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_tgt(ld_tgt),
        .ld_addr(ld_addr), .ld_data(ld_data), .q_valid(q_valid),
        .q_key(q_key), .r_valid(r_valid), .r_hit(r_hit), .r_data(r_data)
    );

    function automatic int find_pos(int k);
        for (int i = 1; i <= N; i++) if (skeys[i] == k) return i;
        return 0;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit ldv, int tgt, int addr, int dat, bit qv, int qk);
        int s;
        int t;
        int pos;
        bit acc;
        @(negedge clk);
        s = cyc % 64;
        if (exp_v[s]) begin
            check(r_valid == 1'b1, exp_tag[s], "r_valid", int'(r_valid), 1);
            check(r_hit == exp_h[s], exp_tag[s], "r_hit", int'(r_hit), int'(exp_h[s]));
            if (exp_h[s])
                check(int'(r_data) == exp_d[s], exp_tag[s], "r_data", int'(r_data), exp_d[s]);
        end else if (r_valid || exp_tag[s] != "") begin
            check(r_valid == 1'b0, (exp_tag[s] != "") ? exp_tag[s] : "R4",
                  "unexpected r_valid", int'(r_valid), 0);
        end
        exp_v[s] = 1'b0;
        exp_tag[s] = "";
        ld_en   = ldv;
        ld_tgt  = 2'(tgt);
        ld_addr = LEVELS'(addr);
        ld_data = LD_W'(dat);
        q_valid = qv;
        q_key   = KEY_W'(qk);
        acc = qv && !ldv && !prev_ld;
        t = (cyc + LAT) % 64;
        if (acc) begin
            pos = find_pos(qk);
            exp_v[t]   = 1'b1;
            exp_h[t]   = (pos != 0);
            exp_d[t]   = (pos != 0) ? dmem[mapv[pos]] : 0;
            exp_tag[t] = (pos != 0) ? cur_tag : "R3";
        end else if (qv) begin
            exp_tag[t] = ldv ? "R6" : "R8";
        end
        if (ldv) begin
            if (tgt == 0) skeys[addr] = dat;
            else if (tgt == 1) mapv[addr] = dat;
            else if (tgt == 2) dmem[addr] = dat;
        end
        prev_ld = ldv;
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    // R5: fill all three stores through the load port
    task automatic load_table(int base);
        int perm [N];
        int kv;
        for (int i = 0; i < N; i++) perm[i] = i;
        for (int i = N - 1; i > 0; i--) begin
            int j = $urandom % (i + 1);
            int tmp = perm[i];
            perm[i] = perm[j];
            perm[j] = tmp;
        end
        kv = base;
        for (int i = 1; i <= N; i++) begin
            kv = kv + 2 + ($urandom % 40);
            step(1, 0, i, kv, 0, 0);
        end
        for (int i = 1; i <= N; i++) step(1, 1, i, perm[i-1], 0, 0);
        for (int a = 0; a < N; a++) step(1, 2, a, $urandom % 65536, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) begin
            exp_v[i] = 1'b0;
            exp_tag[i] = "";
        end
        for (int i = 0; i <= N; i++) begin
            skeys[i] = -1;
            mapv[i] = 0;
            dmem[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: output idle during reset
        check(r_valid == 1'b0, "R1", "r_valid in reset", int'(r_valid), 0);
        rst_n = 1'b1;
        idle(2);
        check(r_valid == 1'b0, "R1", "r_valid after reset", int'(r_valid), 0);

        load_table(3);
        // R6: query alongside an ignored target-3 load over a live data word
        step(1, 3, mapv[5], 16'hDEAD, 1, skeys[3]);
        // R8: settle cycle drops the query
        step(0, 0, 0, 0, 1, skeys[2]);
        idle(1);

        // R2 R4 R7: every stored key back to back, including both ends
        cur_tag = "R2";
        for (int i = 1; i <= N; i++) begin
            cur_tag = (i == 1 || i == N) ? "R7" : "R2";
            step(0, 0, 0, 0, 1, skeys[i]);
        end
        cur_tag = "R6";
        step(0, 0, 0, 0, 1, skeys[5]);
        // R3 R7: absent keys in gaps and outside the range
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1, skeys[N] + 1);
        for (int i = 1; i <= N; i++) step(0, 0, 0, 0, 1, skeys[i] + 1);
        // R4: random mix of present and absent queries
        cur_tag = "R4";
        for (int i = 0; i < 80; i++) begin
            int p = 1 + ($urandom % N);
            bit gap = $urandom % 3 == 0;
            bit qv = $urandom % 8 != 0;
            step(0, 0, 0, 0, qv, gap ? skeys[p] - 1 : skeys[p]);
        end
        idle(LAT + 2);

        // R5: reload a fresh table and query it again
        load_table(500);
        idle(1);
        cur_tag = "R5";
        for (int i = N; i >= 1; i--) step(0, 0, 0, 0, 1, skeys[i]);
        cur_tag = "R4";
        for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 1, $urandom % 1200);
        idle(LAT + 2);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule